// File: doc/BRIEF.md
# Floating-Point Exception Status Register

This block holds the floating-point status word next to an arithmetic datapath. Each time an operation completes, the datapath presents five raw IEEE exception flags. The block records them as the current exceptions. It tests them against a software-programmed trap-enable mask. It then either raises a one-cycle trap request or folds the flags into the sticky accumulated-exception field.

The block also holds the rounding-direction field and drives a registered rounding-mode output back to the datapath. It keeps the two condition-code bits that a compare writes, and a queue-not-empty bit. It offers three kinds of software write, which differ in which fields they leave alone. The readable word is rebuilt from these pieces, with a fixed read-only version number placed on top.

Top module: `fsr_ctrl`

## Requirements
- R1: Status-word layout (read and write alike): cexc[4:0], aexc[9:5], fcc[11:10], qne[13], ftt[16:14], ver[19:17], tem[27:23], rd[31:30]; other bits read 0. Flag and exception bit order inside cexc, aexc, tem and op_flags is invalid=4, overflow=3, underflow=2, divide-by-zero=1, inexact=0.
- R2: On an accepted operation (op_valid), cexc takes op_flags exactly, including all-zero flags, which clear cexc.
- R3: When op_flags AND tem is nonzero, trap_req is 1 for exactly the one cycle in which the updated status is first visible, and ftt becomes 1 (IEEE exception).
- R4: A trapping operation leaves aexc unchanged.
- R5: A non-trapping operation ORs op_flags into aexc and sets ftt to 0.
- R6: round_mode follows rd with the codes 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity, updating in the same cycle as rd.
- R7: A write with wr_mode 0 loads cexc, aexc, fcc, qne, ftt, tem and rd from wr_data.
- R8: A write with wr_mode 1 loads cexc, aexc, ftt, tem and rd; fcc and qne are kept.
- R9: A write with wr_mode 2 loads cexc, aexc, tem and rd; ftt, fcc and qne are kept.
- R10: A write with wr_mode 3 has no effect.
- R11: The ver field always reads the VER_ID parameter, and write data cannot change it.
- R12: A compare (cmp_valid) loads fcc from cmp_cc; the unordered code 3 also sets the invalid bit of aexc.
- R13: An effective write in the same cycle as an operation or compare wins: the operation is dropped and no trap is raised.
- R14: After reset every field is 0 except ver, trap_req is 0 and round_mode is nearest-even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An arithmetic operation completed this cycle |
| op_flags | input | 5 | Raw IEEE flags of that operation |
| cmp_valid | input | 1 | A compare completed this cycle |
| cmp_cc | input | 2 | Compare result: 0 equal, 1 less, 2 greater, 3 unordered |
| wr_en | input | 1 | Software write strobe |
| wr_mode | input | 2 | Write kind: 0 full, 1 keep condition codes, 2 keep condition codes and trap type, 3 none |
| wr_data | input | 32 | Write data in the status-word layout |
| rd_data | output | 32 | Assembled status word |
| trap_req | output | 1 | One-cycle trap request |
| round_mode | output | 2 | Registered rounding mode for the datapath |

## Verification
The hardest state to reach from the ports is a nonzero trap type that must survive a restricted write. It exists only after a trapping operation, and the next operation overwrites it. The stimulus therefore first programs a trap-enable mask with a full write, then fires an enabled flag to leave ftt at 1. It then issues a mode-2 write whose data carries a different trap type, and reads the word back. The priority of a write over an operation in the same cycle is reached in a similar way. The mask is armed first, so that the dropped operation would have trapped had it been accepted.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int WORD_W   = 32;
  localparam int EXC_W    = 5;
  localparam int FTT_W    = 3;
  localparam int FCC_W    = 2;
  localparam int RD_W     = 2;
  localparam int VER_W    = 3;

  localparam int CEXC_LSB = 0;
  localparam int AEXC_LSB = 5;
  localparam int FCC_LSB  = 10;
  localparam int QNE_POS  = 13;
  localparam int FTT_LSB  = 14;
  localparam int VER_LSB  = 17;
  localparam int TEM_LSB  = 23;
  localparam int RD_LSB   = 30;

  localparam int NV_POS   = EXC_W - 1;
  localparam logic [FTT_W-1:0] FTT_IEEE = FTT_W'(1);
  localparam logic [FCC_W-1:0] CC_UNORD = '1;

  typedef enum logic [1:0] {
    WR_ALL    = 2'd0,
    WR_NOCC   = 2'd1,
    WR_KEEPTT = 2'd2,
    WR_NONE   = 2'd3
  } wr_kind_e;

  typedef enum logic [1:0] {
    RND_NEAR = 2'd0,
    RND_ZERO = 2'd1,
    RND_UP   = 2'd2,
    RND_DOWN = 2'd3
  } rnd_e;

  typedef struct packed {
    logic [RD_W-1:0]  rd;
    logic [EXC_W-1:0] tem;
    logic [FTT_W-1:0] ftt;
    logic             qne;
    logic [FCC_W-1:0] fcc;
    logic [EXC_W-1:0] aexc;
    logic [EXC_W-1:0] cexc;
  } fsr_state_t;

  function automatic fsr_state_t word_to_state(input logic [WORD_W-1:0] w);
    fsr_state_t s;
    s.rd   = w[RD_LSB  +: RD_W];
    s.tem  = w[TEM_LSB +: EXC_W];
    s.ftt  = w[FTT_LSB +: FTT_W];
    s.qne  = w[QNE_POS];
    s.fcc  = w[FCC_LSB +: FCC_W];
    s.aexc = w[AEXC_LSB +: EXC_W];
    s.cexc = w[CEXC_LSB +: EXC_W];
    return s;
  endfunction
endpackage

// File: rtl/fsr_exc_eval.sv
module fsr_exc_eval
  import fsr_pkg::*;
(
  input  logic [EXC_W-1:0] flags,
  input  logic [EXC_W-1:0] tem,
  input  logic [EXC_W-1:0] aexc_cur,
  output logic [EXC_W-1:0] cexc_nx,
  output logic [FTT_W-1:0] ftt_nx,
  output logic [EXC_W-1:0] aexc_nx,
  output logic             trap_nx
);
  logic [EXC_W-1:0] hit;

  for (genvar b = 0; b < EXC_W; b++) begin : g_hit
    assign hit[b] = flags[b] & tem[b];
  end

  always_comb begin
    trap_nx = |hit;
    cexc_nx = flags;
    if (trap_nx) begin
      ftt_nx  = FTT_IEEE;
      aexc_nx = aexc_cur;
    end else begin
      ftt_nx  = '0;
      aexc_nx = aexc_cur | flags;
    end
  end
endmodule

// File: rtl/fsr_round_dec.sv
module fsr_round_dec
  import fsr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [RD_W-1:0] rd_nx,
  output logic [1:0]      round_mode
);
  rnd_e mode_d, mode_q;

  always_comb begin
    case (rd_nx)
      2'd0:    mode_d = RND_NEAR;
      2'd1:    mode_d = RND_ZERO;
      2'd2:    mode_d = RND_UP;
      default: mode_d = RND_DOWN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= RND_NEAR;
    else     mode_q <= mode_d;
  end

  assign round_mode = mode_q;
endmodule

// File: rtl/fsr_read_pack.sv
module fsr_read_pack
  import fsr_pkg::*;
#(
  parameter logic [VER_W-1:0] VER_ID = 3'd4
) (
  input  fsr_state_t        st,
  output logic [WORD_W-1:0] word
);
  always_comb begin
    word = '0;
    word[RD_LSB   +: RD_W]  = st.rd;
    word[TEM_LSB  +: EXC_W] = st.tem;
    word[VER_LSB  +: VER_W] = VER_ID;
    word[FTT_LSB  +: FTT_W] = st.ftt;
    word[QNE_POS]           = st.qne;
    word[FCC_LSB  +: FCC_W] = st.fcc;
    word[AEXC_LSB +: EXC_W] = st.aexc;
    word[CEXC_LSB +: EXC_W] = st.cexc;
  end
endmodule

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import fsr_pkg::*;
#(
  parameter logic [VER_W-1:0] VER_ID = 3'd4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [EXC_W-1:0]  op_flags,
  input  logic              cmp_valid,
  input  logic [FCC_W-1:0]  cmp_cc,
  input  logic              wr_en,
  input  logic [1:0]        wr_mode,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              trap_req,
  output logic [1:0]        round_mode
);
  fsr_state_t st, st_n, wr_st;
  logic       trap_q, trap_d;
  logic       wr_take;
  wr_kind_e   kind;

  logic [EXC_W-1:0] cexc_nx, aexc_nx;
  logic [FTT_W-1:0] ftt_nx;
  logic             trap_nx;

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[29:28], wr_data[22:20], wr_data[19:17], wr_data[12]};

  assign kind    = wr_kind_e'(wr_mode);
  assign wr_take = wr_en && (kind != WR_NONE);
  assign wr_st   = word_to_state(wr_data);

  fsr_exc_eval u_eval (
    .flags    (op_flags),
    .tem      (st.tem),
    .aexc_cur (st.aexc),
    .cexc_nx  (cexc_nx),
    .ftt_nx   (ftt_nx),
    .aexc_nx  (aexc_nx),
    .trap_nx  (trap_nx)
  );

  always_comb begin
    st_n   = st;
    trap_d = 1'b0;
    if (wr_take) begin
      st_n.rd   = wr_st.rd;
      st_n.tem  = wr_st.tem;
      st_n.aexc = wr_st.aexc;
      st_n.cexc = wr_st.cexc;
      case (kind)
        WR_ALL: begin
          st_n.ftt = wr_st.ftt;
          st_n.fcc = wr_st.fcc;
          st_n.qne = wr_st.qne;
        end
        WR_NOCC: st_n.ftt = wr_st.ftt;
        default: ;
      endcase
    end else begin
      if (op_valid) begin
        st_n.cexc = cexc_nx;
        st_n.ftt  = ftt_nx;
        st_n.aexc = aexc_nx;
        trap_d    = trap_nx;
      end
      if (cmp_valid) begin
        st_n.fcc = cmp_cc;
        if (cmp_cc == CC_UNORD) st_n.aexc[NV_POS] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= '0;
      trap_q <= 1'b0;
    end else begin
      st     <= st_n;
      trap_q <= trap_d;
    end
  end

  fsr_round_dec u_round (
    .clk        (clk),
    .rst        (rst),
    .rd_nx      (st_n.rd),
    .round_mode (round_mode)
  );

  fsr_read_pack #(.VER_ID(VER_ID)) u_pack (
    .st   (st),
    .word (rd_data)
  );

  assign trap_req = trap_q;

  AST_TRAP_FTT: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> (rd_data[FTT_LSB +: FTT_W] == FTT_IEEE))
    else $error("trap without IEEE trap type"); // R3

  AST_TRAP_KEEPS_AEXC: assert property (@(posedge clk) disable iff (rst)
    (trap_req && !$past(cmp_valid) && !$past(rst)) |-> $stable(st.aexc))
    else $error("aexc changed on trap"); // R4

  AST_NOTRAP_ACCUM: assert property (@(posedge clk) disable iff (rst)
    ($past(op_valid && !wr_take) && !$past(rst) && !trap_req) |->
      (((st.aexc & $past(op_flags)) == $past(op_flags)) && (st.ftt == '0)))
    else $error("flags not accumulated"); // R5

  AST_ROUND_MATCH: assert property (@(posedge clk) disable iff (rst)
    round_mode == st.rd)
    else $error("round mode out of step with rd"); // R6

  AST_NONE_WRITE: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en && wr_mode == WR_NONE && !op_valid && !cmp_valid) && !$past(rst))
      |-> $stable(rd_data))
    else $error("reserved write changed state"); // R10

  AST_VER_FIXED: assert property (@(posedge clk) disable iff (rst)
    rd_data[VER_LSB +: VER_W] == VER_ID)
    else $error("version field changed"); // R11

  AST_WRITE_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
    $past(wr_take) |-> !trap_req)
    else $error("trap raised under a write"); // R13
endmodule

// File: tb/test_fsr_ctrl.sv
`timescale 1ns/1ps
module test_fsr_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [4:0]  op_flags = '0;
  logic        cmp_valid = 1'b0;
  logic [1:0]  cmp_cc = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_mode = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        trap_req;
  logic [1:0]  round_mode;

  int n_run = 0;
  int n_fail = 0;
  localparam logic [2:0] VER = 3'd4;

  always #2.5 clk = ~clk;

  fsr_ctrl i_fsr_ctrl (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_flags(op_flags),
    .cmp_valid(cmp_valid), .cmp_cc(cmp_cc), .wr_en(wr_en), .wr_mode(wr_mode),
    .wr_data(wr_data), .rd_data(rd_data), .trap_req(trap_req), .round_mode(round_mode)
  );

  // fields: tem, aexc before, flags, trap, cexc, ftt, aexc after
  localparam int NV = 8;
  localparam logic [28:0] VEC [NV] = '{
    {5'b00000, 5'b00000, 5'b10000, 1'b0, 5'b10000, 3'd0, 5'b10000},
    {5'b10000, 5'b00000, 5'b10000, 1'b1, 5'b10000, 3'd1, 5'b00000},
    {5'b01000, 5'b00001, 5'b00101, 1'b0, 5'b00101, 3'd0, 5'b00101},
    {5'b00100, 5'b11000, 5'b00101, 1'b1, 5'b00101, 3'd1, 5'b11000},
    {5'b11111, 5'b00010, 5'b00000, 1'b0, 5'b00000, 3'd0, 5'b00010},
    {5'b00010, 5'b00000, 5'b00010, 1'b1, 5'b00010, 3'd1, 5'b00000},
    {5'b00000, 5'b10101, 5'b01010, 1'b0, 5'b01010, 3'd0, 5'b11111},
    {5'b00001, 5'b00000, 5'b11110, 1'b0, 5'b11110, 3'd0, 5'b11110}
  };

  function automatic logic [31:0] mk(input logic [1:0] rd, input logic [4:0] tem,
                                     input logic [2:0] ftt, input logic qne,
                                     input logic [1:0] fcc, input logic [4:0] aexc,
                                     input logic [4:0] cexc);
    return {rd, 2'b00, tem, 3'b000, VER, ftt, qne, 1'b0, fcc, aexc, cexc};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] mode, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_mode = mode; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_op(input logic [4:0] f);
    @(negedge clk);
    op_valid = 1'b1; op_flags = f;
    @(negedge clk);
    op_valid = 1'b0; op_flags = '0;
  endtask

  task automatic do_cmp(input logic [1:0] cc);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_cc = cc;
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R14 reset state
    check("R14 word", rd_data, mk(0, 0, 0, 0, 0, 0, 0));
    check("R14 trap", {31'd0, trap_req}, 32'd0);
    check("R14 round", {30'd0, round_mode}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      v = VEC[i];
      do_write(2'd0, mk(0, v[28:24], 0, 0, 0, v[23:19], 0));
      do_op(v[18:14]);
      // R2 R3 R4 R5
      check($sformatf("R3 trap vec%0d", i), {31'd0, trap_req}, {31'd0, v[13]});
      check($sformatf("R2 R4 R5 word vec%0d", i), rd_data,
            mk(0, v[28:24], v[7:5], 0, 0, v[4:0], v[12:8]));
      @(negedge clk);
      check($sformatf("R3 pulse end vec%0d", i), {31'd0, trap_req}, 32'd0);
    end

    // R7 R1 R11 full write of all ones
    do_write(2'd0, 32'hFFFF_FFFF);
    check("R7 R1 R11 full write", rd_data, mk(3, 5'h1f, 3'd7, 1, 3, 5'h1f, 5'h1f));
    check("R6 round down", {30'd0, round_mode}, 32'd3);
    for (int r = 0; r < 3; r++) begin
      do_write(2'd0, mk(r[1:0], 0, 0, 0, 0, 0, 0));
      check($sformatf("R6 round %0d", r), {30'd0, round_mode}, r);
    end

    // R8 keeps fcc, qne
    do_write(2'd0, mk(0, 0, 0, 1, 2, 0, 0));
    do_write(2'd1, mk(1, 5'd4, 3'd2, 0, 1, 5'd6, 5'd3));
    check("R8 nocc write", rd_data, mk(1, 5'd4, 3'd2, 1, 2, 5'd6, 5'd3));

    // R9 keeps trap type from a real trap
    do_write(2'd0, mk(0, 5'b00001, 0, 1, 2, 0, 0));
    do_op(5'b00001);
    check("R9 setup trap", rd_data, mk(0, 5'b00001, 3'd1, 1, 2, 0, 5'b00001));
    do_write(2'd2, mk(2, 5'd0, 3'd5, 0, 0, 5'd1, 5'd7));
    check("R9 keeptt write", rd_data, mk(2, 5'd0, 3'd1, 1, 2, 5'd1, 5'd7));

    // R10 reserved write
    do_write(2'd3, 32'h0000_0000);
    check("R10 none write", rd_data, mk(2, 5'd0, 3'd1, 1, 2, 5'd1, 5'd7));

    // R13 write beats op
    do_write(2'd0, mk(0, 5'h1f, 0, 0, 0, 0, 0));
    @(negedge clk);
    wr_en = 1'b1; wr_mode = 2'd0; wr_data = mk(1, 0, 0, 0, 0, 0, 0);
    op_valid = 1'b1; op_flags = 5'h1f;
    @(negedge clk);
    wr_en = 1'b0; op_valid = 1'b0; op_flags = '0;
    check("R13 no trap", {31'd0, trap_req}, 32'd0);
    check("R13 word", rd_data, mk(1, 0, 0, 0, 0, 0, 0));

    // R12 compare
    do_cmp(2'd1);
    check("R12 less", rd_data, mk(1, 0, 0, 0, 1, 0, 0));
    do_cmp(2'd3);
    check("R12 unordered", rd_data, mk(1, 0, 0, 0, 3, 5'b10000, 0));

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule